// File: doc/BRIEF.md
# Select-Synchronized Serial Peripheral Slave

This block is the receive and transmit engine of a serial peripheral (SPI) slave. A remote master supplies the serial clock, the select line and the data input. The block shifts one byte in and one byte out per transfer, most significant bit first. All three serial inputs are brought into the system clock through synchronizer flops, and the block acts on edges of the synchronized serial clock. The serial clock must therefore run slower than a quarter of the system clock.

On the host side, configuration is presented as static levels: an enable, a 4-bit mode code, the clock idle level and the launch-edge choice. The host writes the next transmit byte with a one-cycle strobe and reads the received byte from a holding register. A one-cycle completion pulse marks every finished byte. Sticky flags record a received byte that was lost and a transmit write that was refused.

With mode `4'b0100` the select input gates the block. A low select enables shifting and drives the output. A high select releases the output-enable at once, in the same cycle as the pin and without waiting for the synchronizer, and clears the bit count. With mode `4'b0101` the select input is ignored. Any other mode code, or a low enable, idles the block.

Top module: `spi_sel_slave`

## Requirements
- R1: Each transfer moves `DATA_W` bits MSB first. The received byte is the data-input bit sampled on each sample edge, and the output carries bit `DATA_W-1` of the transmit byte first.
- R2: One system cycle after the last sample edge, `xferDone` is high for exactly one cycle and `rxData` holds the new byte (when it was accepted).
- R3: In mode `4'b0100`, `sdoOe` is 1 while the select is low. While `ssIn` is high, `sdoOe` is 0 in the same cycle, even in the middle of a byte. `sdoOut` keeps its last value while `sdoOe` is 0.
- R4: In mode `4'b0100`, a high synchronized select clears the bit counter. A byte cut short by the select is dropped, and the next selected transfer starts again at the MSB of the transmit byte.
- R5: In mode `4'b0101`, the select input has no effect: transfers complete and `sdoOe` is 1 whenever the block is enabled.
- R6: With `cfgEnable` low, or a mode code other than `4'b0100` or `4'b0101`, no transfer completes and `sdoOe` stays 0.
- R7: Dropping `cfgEnable` in the middle of a byte clears the bit counter. After re-enabling, the next transfer is a full byte.
- R8: `cfgCkp` gives the idle level of the serial clock. The leading edge is the one that leaves that level, and the trailing edge is the one that returns to it.
- R9: With `cfgCke`=0, the block samples on the leading edge and launches on the trailing edge, with the MSB already on the output before the first edge. With `cfgCke`=1, it launches on the leading edge and samples on the trailing edge.
- R10: `cfgError` = `cfgEnable` & `cfgCke` & (mode == `4'b0101`).
- R11: A `txWrite` while the bit counter is zero stores `txData` as the byte for the next transfer. A `txWrite` while the counter is non-zero is ignored and sets `txCollision`. The transmit byte is resent on later transfers until it is rewritten.
- R12: A byte that completes while `rxFull` is set (with no `rxRead` in that cycle) sets `rxOverflow` and leaves `rxData` unchanged. `rxRead` clears `rxFull`, and `flagClr` clears `rxOverflow` and `txCollision`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rstN | input | 1 | asynchronous reset, active low |
| cfgEnable | input | 1 | module enable |
| cfgMode | input | 4 | mode code (0100 select-gated, 0101 select ignored) |
| cfgCkp | input | 1 | serial clock idle level |
| cfgCke | input | 1 | launch-edge choice |
| txWrite | input | 1 | transmit byte write strobe |
| txData | input | DATA_W | transmit byte |
| rxRead | input | 1 | receive byte read strobe |
| flagClr | input | 1 | clears the sticky error flags |
| rxData | output | DATA_W | last accepted received byte |
| xferDone | output | 1 | one-cycle completion pulse |
| rxFull | output | 1 | unread received byte present |
| rxOverflow | output | 1 | sticky lost-byte flag |
| txCollision | output | 1 | sticky refused-write flag |
| cfgError | output | 1 | illegal configuration |
| sckIn | input | 1 | serial clock from master |
| ssIn | input | 1 | slave select, active low |
| sdiIn | input | 1 | serial data in |
| sdoOut | output | 1 | serial data out |
| sdoOe | output | 1 | output-enable for the data-out pad |

## Verification
The bench uses the default parameters, `DATA_W`=8 and `SYNC_STAGES`=2, and holds each serial clock phase for 8 system cycles. This leaves room for the synchronizer latency and still gives a fast run. With 8-bit bytes, the bench can predict the result of random bytes across all four clock polarity and phase combinations. It also covers the mid-byte cases: a select abort after three bits, an enable drop, and a refused write at bit three. Back-to-back unread bytes drive the overflow path.

// File: rtl/spi_sel_pkg.sv
package spi_sel_pkg;

  localparam logic [3:0] MODE_SS_ON  = 4'b0100;
  localparam logic [3:0] MODE_SS_OFF = 4'b0101;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;   // accepted host write
    logic reload;   // block idle: shift register follows transmit buffer
    logic shift;    // sample edge: shift in one bit
    logic finish;   // last bit sampled
    logic rxStore;  // move assembled byte into receive buffer
    logic sdoLoad;  // launch next output bit
    logic sdiBit;   // synchronized data-in bit
  } strobe_t;

endpackage

// File: rtl/spi_sel_dp.sv
module spi_sel_dp
  import spi_sel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              sdo
);

  logic [DATA_W-1:0] txBuf;
  logic [DATA_W-1:0] shReg;
  logic [DATA_W-1:0] rxBuf;
  logic              sdoReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf  <= '0;
      shReg  <= '0;
      rxBuf  <= '0;
      sdoReg <= 1'b0;
    end else begin
      if (st.txLoad) begin
        txBuf <= txData;
        shReg <= txData;
      end else if (st.reload || st.finish) begin
        shReg <= txBuf;
      end else if (st.shift) begin
        shReg <= {shReg[DATA_W-2:0], st.sdiBit};
      end
      if (st.rxStore) rxBuf <= {shReg[DATA_W-2:0], st.sdiBit};
      if (st.sdoLoad) sdoReg <= shReg[DATA_W-1];
    end
  end

  assign rxData = rxBuf;
  assign sdo    = sdoReg;

  // R1: a plain sample edge puts the sampled bit at the LSB
  p_shift_lsb_r1: assert property (@(posedge clk) disable iff (!rstN)
    (st.shift && !st.finish && !st.txLoad && !st.reload) |=> shReg[0] == $past(st.sdiBit));

endmodule

// File: rtl/spi_sel_ctrl.sv
module spi_sel_ctrl
  import spi_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnable,
  input  logic [3:0] cfgMode,
  input  logic       cfgCkp,
  input  logic       cfgCke,
  input  logic       txWrite,
  input  logic       rxRead,
  input  logic       flagClr,
  input  logic       sckIn,
  input  logic       ssIn,
  input  logic       sdiIn,
  output strobe_t    st,
  output logic       xferDone,
  output logic       rxFull,
  output logic       rxOverflow,
  output logic       txCollision,
  output logic       cfgError,
  output logic       sdoOe
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] sckSh, ssSh, sdiSh;
  logic sckPrev, sckS, ssS;
  logic [CNT_W-1:0] bitCnt;
  logic slaveOn, ssCtrl, active, sckMoved, leadEdge, trailEdge, sampleEdge;
  logic lastBit, txAccept, rxAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh   <= '0;
      ssSh    <= '1;
      sdiSh   <= '0;
      sckPrev <= 1'b0;
    end else begin
      sckSh   <= {sckSh[SYNC_STAGES-2:0], sckIn};
      ssSh    <= {ssSh[SYNC_STAGES-2:0], ssIn};
      sdiSh   <= {sdiSh[SYNC_STAGES-2:0], sdiIn};
      sckPrev <= sckS;
    end
  end

  assign sckS = sckSh[SYNC_STAGES-1];
  assign ssS  = ssSh[SYNC_STAGES-1];

  assign ssCtrl     = (cfgMode == MODE_SS_ON);
  assign slaveOn    = cfgEnable && (ssCtrl || cfgMode == MODE_SS_OFF);
  assign active     = slaveOn && (!ssCtrl || !ssS);
  assign sckMoved   = sckS ^ sckPrev;
  assign leadEdge   = active && sckMoved && (sckS != cfgCkp);
  assign trailEdge  = active && sckMoved && (sckS == cfgCkp);
  assign sampleEdge = cfgCke ? trailEdge : leadEdge;
  assign lastBit    = sampleEdge && (bitCnt == LAST);
  assign txAccept   = txWrite && (bitCnt == '0);
  assign rxAccept   = lastBit && (!rxFull || rxRead);

  always_comb begin
    st.txLoad  = txAccept;
    st.reload  = !active;
    st.shift   = sampleEdge;
    st.finish  = lastBit;
    st.rxStore = rxAccept;
    st.sdoLoad = active && (cfgCke ? leadEdge : (sckS == cfgCkp));
    st.sdiBit  = sdiSh[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt      <= '0;
      xferDone    <= 1'b0;
      rxFull      <= 1'b0;
      rxOverflow  <= 1'b0;
      txCollision <= 1'b0;
    end else begin
      if (!active)         bitCnt <= '0;
      else if (sampleEdge) bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
      xferDone <= lastBit;
      if (rxAccept)    rxFull <= 1'b1;
      else if (rxRead) rxFull <= 1'b0;
      if (lastBit && !rxAccept) rxOverflow <= 1'b1;
      else if (flagClr)         rxOverflow <= 1'b0;
      if (txWrite && bitCnt != '0) txCollision <= 1'b1;
      else if (flagClr)            txCollision <= 1'b0;
    end
  end

  // output released straight from the pin, enabled from the synchronized view
  assign sdoOe    = active && !(ssCtrl && ssIn);
  assign cfgError = cfgEnable && cfgCke && (cfgMode == MODE_SS_OFF);

  // R4: a deselected slave holds its bit count at zero
  p_cnt_desel_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ssCtrl && ssS) |=> bitCnt == '0);
  // R7: disabling clears the bit count
  p_cnt_disable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |=> bitCnt == '0);
  // R2: completion is a single-cycle pulse
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

endmodule

// File: rtl/spi_sel_slave.sv
module spi_sel_slave
  import spi_sel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic [3:0]        cfgMode,
  input  logic              cfgCkp,
  input  logic              cfgCke,
  input  logic              txWrite,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxRead,
  input  logic              flagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              xferDone,
  output logic              rxFull,
  output logic              rxOverflow,
  output logic              txCollision,
  output logic              cfgError,
  input  logic              sckIn,
  input  logic              ssIn,
  input  logic              sdiIn,
  output logic              sdoOut,
  output logic              sdoOe
);

  strobe_t st;

  spi_sel_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgCkp(cfgCkp), .cfgCke(cfgCke), .txWrite(txWrite), .rxRead(rxRead),
    .flagClr(flagClr), .sckIn(sckIn), .ssIn(ssIn), .sdiIn(sdiIn), .st(st),
    .xferDone(xferDone), .rxFull(rxFull), .rxOverflow(rxOverflow),
    .txCollision(txCollision), .cfgError(cfgError), .sdoOe(sdoOe)
  );

  spi_sel_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .txData(txData),
    .rxData(rxData), .sdo(sdoOut)
  );

  // R3: a high select in gated mode never leaves the pad driven
  p_oe_ss_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_SS_ON && ssIn) |-> !sdoOe);
  // R6: disabled or non-slave mode keeps the pad released
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable || (cfgMode != MODE_SS_ON && cfgMode != MODE_SS_OFF)) |-> !sdoOe);
  // R12: a lost byte does not disturb the held byte
  p_rx_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverflow) |-> $stable(rxData));

endmodule

// File: tb/sim_spi_sel_slave.sv
module sim_spi_sel_slave;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnable = 1'b0, cfgCkp = 1'b0, cfgCke = 1'b0;
  logic [3:0] cfgMode = 4'b0100;
  logic txWrite = 1'b0, rxRead = 1'b0, flagClr = 1'b0;
  logic [7:0] txData = '0;
  logic [7:0] rxData;
  logic xferDone, rxFull, rxOverflow, txCollision, cfgError;
  logic sckIn = 1'b0, ssIn = 1'b1, sdiIn = 1'b0;
  logic sdoOut, sdoOe;

  int total = 0, bad = 0, doneCnt = 0;

  always #2.5 clk = ~clk;

  spi_sel_slave u0 (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgMode(cfgMode),
    .cfgCkp(cfgCkp), .cfgCke(cfgCke), .txWrite(txWrite), .txData(txData),
    .rxRead(rxRead), .flagClr(flagClr), .rxData(rxData), .xferDone(xferDone),
    .rxFull(rxFull), .rxOverflow(rxOverflow), .txCollision(txCollision),
    .cfgError(cfgError), .sckIn(sckIn), .ssIn(ssIn), .sdiIn(sdiIn),
    .sdoOut(sdoOut), .sdoOe(sdoOe)
  );

  always @(negedge clk) if (rstN && xferDone) doneCnt++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expCfgErr(logic en, logic cke, logic [3:0] m);
    return {7'd0, en & cke & (m == 4'b0101)};
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk); txData = b; txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
  endtask

  // master side: sends mosi bits [7-startBit ...], collects sdo bits
  task automatic frame(input logic [7:0] mosi, input int startBit, input int nbits,
                       output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      if (!cfgCke) begin
        @(negedge clk); sdiIn = mosi[7-(startBit+i)];
        waitc(HALF);
        got = {got[6:0], sdoOut};
        sckIn = ~cfgCkp;
        waitc(HALF);
        sckIn = cfgCkp;
      end else begin
        @(negedge clk); sckIn = ~cfgCkp;
        waitc(HALF/2);
        sdiIn = mosi[7-(startBit+i)];
        waitc(HALF/2);
        got = {got[6:0], sdoOut};
        sckIn = cfgCkp;
        waitc(HALF);
      end
    end
    waitc(HALF);
  endtask

  task automatic setCfg(input logic en, input logic [3:0] m, input logic ckp, input logic cke);
    @(negedge clk);
    cfgEnable = 1'b0; cfgMode = m; cfgCkp = ckp; cfgCke = cke; sckIn = ckp;
    waitc(6);
    cfgEnable = en;
    waitc(2);
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] got, got2, tb, mb;
    int d0;
    logic held;
    void'($urandom(32'd1234));
    waitc(3);
    rstN = 1'b1;
    waitc(2);
    // reset state
    chk("R3 reset oe", sdoOe, 0);
    chk("R2 reset rx", rxData, 0);
    chk("R12 reset flags", {rxFull, rxOverflow, txCollision}, 0);

    // basic transfer, mode 0100, ckp0 cke0
    setCfg(1'b1, 4'b0100, 1'b0, 1'b0);
    hostWrite(8'hA5);
    ssIn = 1'b0; waitc(6);
    chk("R3 oe when selected", sdoOe, 1);
    d0 = doneCnt;
    frame(8'h3C, 0, 8, got);
    chk("R1 rx byte", rxData, 8'h3C);
    chk("R1 tx msb first", got, 8'hA5);
    chk("R2 one done pulse", doneCnt - d0, 1);
    chk("R12 rxFull set", rxFull, 1);
    ssIn = 1'b1;
    pulse(rxRead); waitc(1);
    chk("R12 rxRead clears", rxFull, 0);

    // random transfers over polarity and phase (R8, R9)
    for (int k = 0; k < 16; k++) begin
      logic ckp, cke;
      ckp = 1'($urandom); cke = 1'($urandom);
      tb = 8'($urandom); mb = 8'($urandom);
      setCfg(1'b1, 4'b0100, ckp, cke);
      hostWrite(tb);
      ssIn = 1'b0; waitc(6);
      d0 = doneCnt;
      frame(mb, 0, 8, got);
      chk("R8 R9 random rx", rxData, mb);
      chk("R8 R9 random tx", got, tb);
      chk("R2 random done", doneCnt - d0, 1);
      ssIn = 1'b1;
      pulse(rxRead);
    end

    // select abort mid-byte (R3, R4)
    setCfg(1'b1, 4'b0100, 1'b0, 1'b0);
    hostWrite(8'hC3);
    ssIn = 1'b0; waitc(6);
    d0 = doneCnt;
    frame(8'hFF, 0, 3, got);
    @(negedge clk); held = sdoOut; ssIn = 1'b1; #1;
    chk("R3 oe drops at once", sdoOe, 0);
    waitc(6);
    chk("R3 sdo held", sdoOut, held);
    chk("R4 no done on abort", doneCnt - d0, 0);
    ssIn = 1'b0; waitc(6);
    frame(8'h5A, 0, 8, got);
    chk("R4 fresh byte rx", rxData, 8'h5A);
    chk("R4 restart at msb", got, 8'hC3);
    ssIn = 1'b1; pulse(rxRead);

    // enable drop mid-byte (R7)
    ssIn = 1'b0; waitc(6);
    frame(8'h00, 0, 4, got);
    @(negedge clk); cfgEnable = 1'b0; waitc(4);
    chk("R7 oe off", sdoOe, 0);
    cfgEnable = 1'b1; waitc(6);
    d0 = doneCnt;
    frame(8'h96, 0, 8, got);
    chk("R7 full byte after re-enable", rxData, 8'h96);
    chk("R7 one done", doneCnt - d0, 1);
    ssIn = 1'b1; pulse(rxRead);

    // refused write mid-byte (R11)
    hostWrite(8'h81);
    ssIn = 1'b0; waitc(6);
    frame(8'h12, 0, 3, got);
    hostWrite(8'h7E);
    chk("R11 collision flag", txCollision, 1);
    frame(8'h12, 3, 5, got2);
    chk("R11 byte in flight kept", {got[2:0], got2[4:0]}, 8'h81);
    chk("R11 rx unaffected", rxData, 8'h12);
    ssIn = 1'b1; pulse(rxRead);
    ssIn = 1'b0; waitc(6);
    frame(8'h34, 0, 8, got);
    chk("R11 refused byte not sent", got, 8'h81);
    ssIn = 1'b1; pulse(rxRead);
    pulse(flagClr); waitc(1);
    chk("R12 flagClr clears collision", txCollision, 0);

    // overflow (R12)
    ssIn = 1'b0; waitc(6);
    frame(8'h11, 0, 8, got);
    frame(8'h22, 0, 8, got);
    chk("R12 overflow set", rxOverflow, 1);
    chk("R12 old byte kept", rxData, 8'h11);
    ssIn = 1'b1;
    pulse(flagClr); waitc(1);
    chk("R12 overflow cleared", rxOverflow, 0);
    chk("R12 still full", rxFull, 1);
    pulse(rxRead);

    // select ignored (R5)
    setCfg(1'b1, 4'b0101, 1'b1, 1'b0);
    hostWrite(8'h6B);
    waitc(4);
    chk("R5 oe with select high", sdoOe, 1);
    d0 = doneCnt;
    frame(8'hE7, 0, 8, got);
    chk("R5 rx with select high", rxData, 8'hE7);
    chk("R5 tx with select high", got, 8'h6B);
    chk("R5 done", doneCnt - d0, 1);
    pulse(rxRead);

    // idle modes (R6)
    setCfg(1'b1, 4'b0000, 1'b0, 1'b0);
    ssIn = 1'b0; waitc(6);
    d0 = doneCnt;
    frame(8'h99, 0, 8, got);
    chk("R6 no done bad mode", doneCnt - d0, 0);
    chk("R6 oe off bad mode", sdoOe, 0);
    setCfg(1'b0, 4'b0100, 1'b0, 1'b0);
    frame(8'h99, 0, 8, got);
    chk("R6 no done disabled", doneCnt - d0, 0);
    chk("R6 rx unchanged", rxData, 8'hE7);
    ssIn = 1'b1;

    // configuration error (R10)
    for (int k = 0; k < 8; k++) begin
      logic [3:0] m;
      m = k[0] ? 4'b0101 : 4'b0100;
      @(negedge clk); cfgEnable = k[1]; cfgCke = k[2]; cfgMode = m; #1;
      chk("R10 cfgError", cfgError, expCfgErr(k[1], k[2], m));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule